// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

The block gathers up to 32 peripheral interrupt request lines and three system exception sources: system reset request, non-maskable interrupt and hard fault. The system sources have fixed priorities above everything else. Each peripheral line has an enable bit and a two-bit priority. That priority is held in the top two bits of a byte-wide field, so the four levels read back as 0x00, 0x40, 0x80 and 0xC0.

The controller keeps a pending bit for every source. It picks the eligible source with the highest priority and presents its vector number to the core, but only when that source may preempt the handler that is running. The core acknowledges the presented vector, and the level it is running at becomes that vector's priority. On return from a handler the previous level comes back from a nesting stack, and the pending sources are weighed again against it. Software programs enables and priorities through a plain word-addressed register bus. Enables are changed through separate set and clear registers.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Vector numbers are fixed: system reset request is 1, non-maskable interrupt is 2, hard fault is 3, and peripheral line n is 16+n. The eligible source with the numerically lowest priority wins.
- R2: The priority of line n is the byte n%4 of the word at byte address 0x10+4*(n/4). Only bits 7:6 of that byte are stored. The other six bits read as zero.
- R3: The system sources rank at -3 (reset request), -2 (non-maskable) and -1 (hard fault). They beat every programmable level, whatever the enable and priority registers hold.
- R4: When eligible sources share the best priority, the lower vector number wins.
- R5: A write to address 0x00 sets each enable bit whose data bit is 1. A write to address 0x04 clears each enable bit whose data bit is 1. Data bits at 0 leave the enable unchanged. Both addresses read back the enable mask.
- R6: A rising edge on a peripheral line sets its pending bit even while the line is disabled. A high level also sets the pending bit while the line is enabled. Only enabled pending lines are eligible. Address 0x08 reads the peripheral pending mask.
- R7: An acknowledge (ack_i high while irq_req_o is high and ret_i is low) clears the pending bit of the presented vector. It also makes that vector's priority the active level.
- R8: irq_req_o rises only when the winning priority is strictly higher than the active level. A source of equal or lower priority waits.
- R9: A ret_i pulse restores the active level that was in force before the most recent acknowledge. The pending sources are then weighed against the restored level.
- R10: When no source may preempt, irq_req_o is low and irq_vec_o is zero.
- R11: After reset, enables, priorities and pending bits are zero and no handler is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQ | Peripheral request lines |
| sys_rst_req_i | input | 1 | System reset request exception |
| nmi_i | input | 1 | Non-maskable interrupt |
| hard_fault_i | input | 1 | Hard fault exception |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i |
| ack_i | input | 1 | Core accepts the presented vector |
| ret_i | input | 1 | Core returns from the current handler |
| irq_req_o | output | 1 | A vector may preempt |
| irq_vec_o | output | VEC_W | Presented vector number, zero when idle |

## Verification
The arbitration is driven with pairs of lines that tie at one level, to see that the lower vector wins. It is also driven with lines at different levels, to see that the numerically lowest priority wins whatever the vector order. A disabled line at the best level shows that pending alone does not make a line eligible. Mixes of system sources with each other and with peripheral lines show the fixed ordering. Two nesting walks cover the rest: the first checks equal-priority blocking, strict preemption and the level restored at each return, and the second checks that a held level line becomes pending again right after its acknowledge.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int SYS_CNT     = 3;
  localparam int PERIPH_BASE = 16;
  localparam int WORD_SETEN  = 0;
  localparam int WORD_CLREN  = 1;
  localparam int WORD_PEND   = 2;
  localparam int WORD_PRIO0  = 4;
endpackage

// File: rtl/nic_regs.sv
module nic_regs
  import nic_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               bus_wr_i,
  input  logic [ADDR_W-1:0]                  bus_addr_i,
  input  logic [31:0]                        bus_wdata_i,
  input  logic [NUM_IRQ-1:0]                 pend_i,
  output logic [NUM_IRQ-1:0]                 en_o,
  output logic [NUM_IRQ-1:0][PRIO_BITS-1:0]  prio_o,
  output logic [31:0]                        bus_rdata_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              unused_addr;

  assign word        = bus_addr_i[ADDR_W-1:2];
  assign unused_addr = ^bus_addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o <= '0;
    end else if (bus_wr_i) begin
      if (word == WORD_W'(WORD_SETEN)) en_o <= en_o | bus_wdata_i[NUM_IRQ-1:0];
      else if (word == WORD_W'(WORD_CLREN)) en_o <= en_o & ~bus_wdata_i[NUM_IRQ-1:0];
    end
  end

  // one byte field per line, upper bits only
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
    localparam int MSB = (i % 4) * 8 + 7;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_o[i] <= '0;
      else if (bus_wr_i && word == WORD_W'(WORD_PRIO0 + i / 4))
        prio_o[i] <= bus_wdata_i[MSB -: PRIO_BITS];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (word == WORD_W'(WORD_SETEN) || word == WORD_W'(WORD_CLREN)) begin
      bus_rdata_o[NUM_IRQ-1:0] = en_o;
    end else if (word == WORD_W'(WORD_PEND)) begin
      bus_rdata_o[NUM_IRQ-1:0] = pend_i;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (word == WORD_W'(WORD_PRIO0 + i / 4))
          bus_rdata_o[(i % 4) * 8 + 7 -: PRIO_BITS] = prio_o[i];
      end
    end
  end
endmodule

// File: rtl/nic_pend.sv
module nic_pend #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic set;
    // edge always latches; held level latches only while enabled
    assign set = req_i[i] & (~req_q[i] | en_i[i]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q[i]  <= 1'b0;
        pend_o[i] <= 1'b0;
      end else begin
        req_q[i] <= req_i[i];
        if (clr_i[i])  pend_o[i] <= 1'b0;
        else if (set)  pend_o[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nic_arb.sv
module nic_arb #(
  parameter int N     = 35,
  parameter int LVL_W = 3,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]            elig_i,
  input  logic [N-1:0][LVL_W-1:0] lvl_i,
  output logic                    found_o,
  output logic [LVL_W-1:0]        win_lvl_o,
  output logic [IDX_W-1:0]        win_idx_o
);
  // ascending scan, strict compare keeps the lower index on ties
  always_comb begin
    found_o   = 1'b0;
    win_lvl_o = '1;
    win_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!found_o || lvl_i[i] < win_lvl_o)) begin
        found_o   = 1'b1;
        win_lvl_o = lvl_i[i];
        win_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/nic_nest.sv
module nic_nest #(
  parameter int LVL_W = 3,
  parameter int DEPTH = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [LVL_W-1:0]           push_lvl_i,
  output logic [LVL_W-1:0]           cur_lvl_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o
);
  localparam int PTR_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][LVL_W-1:0] stk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stk_q     <= '0;
      depth_o   <= '0;
      cur_lvl_o <= '1;
    end else if (pop_i) begin
      if (depth_o != '0) begin
        cur_lvl_o <= stk_q[depth_o - 1'b1];
        depth_o   <= depth_o - 1'b1;
      end
    end else if (push_i && depth_o != PTR_W'(DEPTH)) begin
      stk_q[depth_o] <= cur_lvl_o;
      cur_lvl_o      <= push_lvl_i;
      depth_o        <= depth_o + 1'b1;
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 2,
  parameter int ADDR_W    = 8,
  localparam int VEC_W    = $clog2(PERIPH_BASE + NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               sys_rst_req_i,
  input  logic               nmi_i,
  input  logic               hard_fault_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vec_o
);
  localparam int NUM_SRC  = SYS_CNT + NUM_IRQ;
  localparam int IDLE_LVL = SYS_CNT + (1 << PRIO_BITS);
  localparam int LVL_W    = $clog2(IDLE_LVL + 1);
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int DEPTH    = IDLE_LVL;

  logic [NUM_IRQ-1:0]                en_q;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_q;
  logic [NUM_IRQ-1:0]                pend_q;
  logic [SYS_CNT-1:0]                sys_pend;
  logic [NUM_SRC-1:0]                elig;
  logic [NUM_SRC-1:0][LVL_W-1:0]     lvl;
  logic [NUM_SRC-1:0]                clr;
  logic                              found;
  logic [LVL_W-1:0]                  win_lvl;
  logic [IDX_W-1:0]                  win_idx;
  logic [LVL_W-1:0]                  cur_lvl;
  logic [$clog2(DEPTH+1)-1:0]        depth;
  logic                              accept;
  logic [VEC_W-1:0]                  win_vec;

  nic_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .bus_wr_i, .bus_addr_i, .bus_wdata_i,
    .pend_i(pend_q), .en_o(en_q), .prio_o(prio_q), .bus_rdata_o
  );

  nic_pend #(.N(NUM_IRQ)) u_pend_periph (
    .clk_i, .rst_ni, .req_i(irq_i), .en_i(en_q),
    .clr_i(clr[NUM_SRC-1:SYS_CNT]), .pend_o(pend_q)
  );

  nic_pend #(.N(SYS_CNT)) u_pend_sys (
    .clk_i, .rst_ni, .req_i({hard_fault_i, nmi_i, sys_rst_req_i}),
    .en_i('1), .clr_i(clr[SYS_CNT-1:0]), .pend_o(sys_pend)
  );

  assign elig = {pend_q & en_q, sys_pend};

  for (genvar s = 0; s < SYS_CNT; s++) begin : g_sys_lvl
    assign lvl[s] = LVL_W'(s);
  end
  for (genvar p = 0; p < NUM_IRQ; p++) begin : g_per_lvl
    assign lvl[SYS_CNT+p] = LVL_W'(SYS_CNT) + LVL_W'(prio_q[p]);
  end

  nic_arb #(.N(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .elig_i(elig), .lvl_i(lvl), .found_o(found),
    .win_lvl_o(win_lvl), .win_idx_o(win_idx)
  );

  nic_nest #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_nest (
    .clk_i, .rst_ni, .push_i(accept), .pop_i(ret_i),
    .push_lvl_i(win_lvl), .cur_lvl_o(cur_lvl), .depth_o(depth)
  );

  always_comb begin
    if (win_idx < IDX_W'(SYS_CNT)) win_vec = VEC_W'(win_idx) + VEC_W'(1);
    else win_vec = VEC_W'(win_idx) + VEC_W'(PERIPH_BASE - SYS_CNT);
  end

  assign irq_req_o = found && (win_lvl < cur_lvl);
  assign irq_vec_o = irq_req_o ? win_vec : '0;
  assign accept    = ack_i && irq_req_o && !ret_i;
  assign clr       = accept ? (NUM_SRC'(1) << win_idx) : '0;
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int NUM_IRQ = 32,
  parameter int ADDR_W  = 8,
  parameter int VEC_W   = 6,
  parameter int LVL_W   = 3,
  parameter int DEP_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_req_o,
  input logic [VEC_W-1:0]   irq_vec_o,
  input logic               ack_i,
  input logic               ret_i,
  input logic               bus_wr_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [31:0]        bus_wdata_i,
  input logic [NUM_IRQ-1:0] en_q,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [2:0]         sys_pend,
  input logic [LVL_W-1:0]   cur_lvl,
  input logic [DEP_W-1:0]   depth
);
  localparam int PI_W = $clog2(NUM_IRQ);

  logic             acc;
  logic [VEC_W-1:0] vec_q;
  logic [PI_W-1:0]  line;
  logic [PI_W-1:0]  line_q;
  logic             unused_chk;

  assign acc        = ack_i && irq_req_o && !ret_i;
  assign line       = PI_W'(irq_vec_o - VEC_W'(16));
  assign line_q     = PI_W'(vec_q - VEC_W'(16));
  assign unused_chk = ^bus_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else vec_q <= irq_vec_o;
  end

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && irq_vec_o >= VEC_W'(16) |=> !pend_q[line_q]); // R7
  AST_ACK_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> cur_lvl < $past(cur_lvl)); // R8
  AST_RET_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && depth != '0 |=> cur_lvl > $past(cur_lvl)); // R9
  AST_SETEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == '0 && bus_wdata_i[NUM_IRQ-1:0] == '0 |=> $stable(en_q)); // R5
  AST_SYS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sys_pend) && cur_lvl > LVL_W'(2) |-> irq_req_o && irq_vec_o != '0 && irq_vec_o < VEC_W'(4)); // R3
  AST_REQ_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && irq_vec_o >= VEC_W'(16) |-> pend_q[line] && en_q[line]); // R6
endmodule

bind nest_irq_ctrl nic_checker #(
  .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
  .LVL_W(LVL_W), .DEP_W($clog2(DEPTH+1))
) u_chk (
  .clk_i, .rst_ni, .irq_req_o, .irq_vec_o, .ack_i, .ret_i,
  .bus_wr_i, .bus_addr_i, .bus_wdata_i,
  .en_q, .pend_q, .sys_pend, .cur_lvl, .depth
);

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq = '0;
  logic [2:0]  sys = '0; // {hard fault, nmi, reset request}
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack = 1'b0;
  logic        ret = 1'b0;
  logic        req;
  logic [5:0]  vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq),
    .sys_rst_req_i(sys[0]), .nmi_i(sys[1]), .hard_fault_i(sys[2]),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .ack_i(ack), .ret_i(ret),
    .irq_req_o(req), .irq_vec_o(vec)
  );

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] lines;
    logic [2:0]  sys;
    logic        req;
    logic [5:0]  vec;
  } vec_t;

  // priorities: line3,7 -> 0x40, line20 -> 0x00, line31 -> 0x80, rest 0xC0
  localparam vec_t TBL [10] = '{
    '{32'hFFFF_FFFF, 32'h0000_0003, 3'b000, 1'b1, 6'd16}, // R4 tie at 0xC0
    '{32'hFFFF_FFFF, 32'h0000_000A, 3'b000, 1'b1, 6'd19}, // R1 level beats order
    '{32'hFFFF_FFFF, 32'h0000_0088, 3'b000, 1'b1, 6'd19}, // R4 tie at 0x40
    '{32'hFFFF_FFFF, 32'h8010_0080, 3'b000, 1'b1, 6'd36}, // R1 level 0 wins
    '{32'hFFEF_FFFF, 32'h8010_0000, 3'b000, 1'b1, 6'd47}, // R6 disabled skipped
    '{32'h0000_0000, 32'h0000_0020, 3'b000, 1'b0, 6'd0 }, // R10 nothing eligible
    '{32'hFFFF_FFFF, 32'h0010_0000, 3'b010, 1'b1, 6'd2 }, // R3 nmi over level 0
    '{32'hFFFF_FFFF, 32'h0000_0000, 3'b110, 1'b1, 6'd2 }, // R3 nmi over fault
    '{32'hFFFF_FFFF, 32'h0000_0000, 3'b101, 1'b1, 6'd1 }, // R3 reset req first
    '{32'hFFFF_FFFF, 32'h0010_0000, 3'b100, 1'b1, 6'd3 }  // R3 fault over level 0
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic exp_req, input logic [5:0] exp_vec);
    chk(req === exp_req && vec === exp_vec, tag, {25'd0, req, vec}, {25'd0, exp_req, exp_vec});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; irq = '0; sys = '0; ack = 1'b0; ret = 1'b0; bus_wr = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic prog_prio();
    wr(8'h10, 32'h40C0_C0C0);
    wr(8'h14, 32'h40C0_C0C0);
    wr(8'h18, 32'hC0C0_C0C0);
    wr(8'h1C, 32'hC0C0_C0C0);
    wr(8'h20, 32'hC0C0_C0C0);
    wr(8'h24, 32'hC0C0_C000);
    wr(8'h28, 32'hC0C0_C0C0);
    wr(8'h2C, 32'h80C0_C0C0);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulse_ret();
    ret = 1'b1; tick(); ret = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;

    // R11 reset state
    do_reset();
    chk_out("R11 idle outputs", 1'b0, 6'd0);
    rd(8'h00, d); chk(d == 32'h0, "R11 enable", d, 32'h0);
    rd(8'h08, d); chk(d == 32'h0, "R11 pending", d, 32'h0);
    rd(8'h10, d); chk(d == 32'h0, "R11 priority", d, 32'h0);

    // table walk over arbitration patterns
    for (int k = 0; k < 10; k++) begin
      do_reset();
      prog_prio();
      wr(8'h00, TBL[k].en);
      irq = TBL[k].lines; sys = TBL[k].sys;
      tick();
      chk_out($sformatf("R1/R3/R4/R6 table %0d", k), TBL[k].req, TBL[k].vec);
      irq = '0; sys = '0;
      tick();
    end

    // R2 priority field storage
    do_reset();
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, d); chk(d == 32'hC0C0_C0C0, "R2 low bits zero", d, 32'hC0C0_C0C0);
    wr(8'h18, 32'h3F80_013F);
    rd(8'h18, d); chk(d == 32'h0080_0000, "R2 only top bits", d, 32'h0080_0000);

    // R5 set/clear enable
    wr(8'h00, 32'h0000_000F);
    wr(8'h04, 32'h0);
    rd(8'h00, d); chk(d == 32'hF, "R5 clear zero no effect", d, 32'hF);
    wr(8'h04, 32'h5);
    rd(8'h00, d); chk(d == 32'hA, "R5 clear ones", d, 32'hA);
    wr(8'h00, 32'h0);
    rd(8'h04, d); chk(d == 32'hA, "R5 set zero no effect", d, 32'hA);

    // R6 edge while disabled latches pending, not eligible
    do_reset();
    irq[4] = 1'b1; tick(); irq[4] = 1'b0; tick();
    rd(8'h08, d); chk(d == 32'h10, "R6 edge pends disabled", d, 32'h10);
    chk_out("R10 disabled pending idle", 1'b0, 6'd0);
    wr(8'h00, 32'h10);
    chk_out("R6 enable exposes pending", 1'b1, 6'd20);

    // nesting walk
    do_reset();
    prog_prio();
    wr(8'h00, 32'hFFFF_FFFF);
    irq[0] = 1'b1; tick(); irq[0] = 1'b0;
    chk_out("R1 line0 request", 1'b1, 6'd16);
    pulse_ack();
    chk_out("R7 after ack idle", 1'b0, 6'd0);
    rd(8'h08, d); chk(d == 32'h0, "R7 ack clears pending", d, 32'h0);
    irq[1] = 1'b1; tick(); irq[1] = 1'b0;
    chk_out("R8 equal prio waits", 1'b0, 6'd0);
    irq[3] = 1'b1; tick(); irq[3] = 1'b0;
    chk_out("R8 higher prio preempts", 1'b1, 6'd19);
    pulse_ack();
    sys[1] = 1'b1; tick(); sys[1] = 1'b0;
    chk_out("R3 nmi preempts handler", 1'b1, 6'd2);
    pulse_ack();
    chk_out("R7 nmi active", 1'b0, 6'd0);
    pulse_ret();
    chk_out("R9 back to line3 level", 1'b0, 6'd0);
    pulse_ret();
    chk_out("R9 back to line0 level", 1'b0, 6'd0);
    pulse_ret();
    chk_out("R9 idle releases line1", 1'b1, 6'd17);

    // R6 held level re-pends after ack
    do_reset();
    wr(8'h00, 32'h4);
    irq[2] = 1'b1; tick();
    chk_out("R6 level request", 1'b1, 6'd18);
    pulse_ack();
    rd(8'h08, d); chk(d == 32'h0, "R7 cleared at ack", d, 32'h0);
    tick();
    rd(8'h08, d); chk(d == 32'h4, "R6 held level re-pends", d, 32'h4);
    irq[2] = 1'b0;
    pulse_ret();
    chk_out("R9 re-evaluated after return", 1'b1, 6'd18);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule